// File: doc/BRIEF.md
# Three-Operand Multi-Cycle Processor Core

This block is a compact 32-bit processor that runs a program held in a single word-wide memory. It steps through each instruction in a fixed sequence of states, and each state makes at most one memory access. Every instruction is one 32-bit word. Its top byte selects the operation, and its three lower bytes name two source registers and a destination register. Loads, stores and branches carry a full 32-bit absolute address in the word that follows them. Branches test a single zero flag, which the most recent arithmetic or logic operation leaves behind.

The memory port answers without wait states. The core presents an address with a read strobe, and the data word is taken in that same cycle. A write strobe commits the data word at the end of its cycle. A synchronous reset starts execution at address 0. The core raises its halted output when it meets a halt word, an unrecognised opcode or an unrecognised branch condition.

Top module: `tri_op_core`

## Requirements
- R1: Reset does the following: it sets PC to 0, clears the zero flag, clears all 32 registers and drops `halted`. In the first cycle after reset is released, the core reads address 0.
- R2: An instruction word holds the opcode in bits [31:24], source 1 in [23:16], source 2 in [15:8] and the destination in [7:0]. A register index uses only the low 5 bits of its byte.
- R3: The register operations are ADD 0x00, SUB 0x01 (source 1 minus source 2), NOT 0x02 (uses source 1 only), AND 0x03, OR 0x04 and MOV 0x05 (copies source 1). Each takes three cycles: a fetch read at PC, an idle decode cycle and an idle execute cycle. It writes the destination and advances PC by 4.
- R4: ADD, SUB, NOT, AND and OR set the zero flag to 1 when their result is zero, and clear it otherwise. MOV, LD, ST and the branch instruction leave the flag unchanged.
- R5: LD (0x06, destination in [7:0]) performs these steps: a fetch read, an idle cycle, a read of the address word at PC+4, and a read at that address. The word read is written to the destination, and PC advances by 8.
- R6: ST (0x07, source in [23:16]) performs these steps: a fetch read, an idle cycle, a read of the address word at PC+4, and a write of the source register to that address. PC advances by 8.
- R7: The branch instruction 0x08 takes its condition from bits [23:16]: 0x00 means always, 0x01 means when the flag is 1, and 0x02 means when the flag is 0. After the fetch, the idle cycle and the target-word read, the next fetch is at the target when the branch is taken, or at PC+8 when it is not.
- R8: HLT (0x09), any opcode above 0x09, and a branch with a condition above 0x02 each stop the core after the fetch and an idle cycle. From then on `halted` stays high and no memory access occurs until reset.
- R9: Read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 32 | Byte address of the current access |
| mem_rdata | input | 32 | Read word, valid in the cycle the read strobe is high |
| mem_wdata | output | 32 | Word to store |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe, committed at the clock edge |
| halted | output | 1 | High once execution has stopped |

## Verification
The hardest situation to reach is a conditional branch whose outcome depends on a zero flag set several instructions earlier, with a MOV or LD in between that would flip the decision if it touched the flag. The test programs deliberately put a MOV of a nonzero value after an AND that produced zero, and an LD of a nonzero word after a SUB that produced zero. The branch that follows then shows at the bus whether the flag survived. The programs also use register bytes above 31 and finish on an unknown condition code and an unknown opcode, so that both halt paths are reached.

// File: rtl/tri_op_core.sv
module tri_op_core #(
  parameter int NREG = 32
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] mem_addr,
  input  logic [31:0] mem_rdata,
  output logic [31:0] mem_wdata,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic        halted
);
  localparam int RIDX = $clog2(NREG);

  typedef enum logic [2:0] {S_FETCH, S_DECODE, S_ADDR, S_MEM, S_EXEC, S_HALT} state_t;

  state_t      st;
  logic [31:0] pc, ir, ar;
  logic        zf;
  logic [31:0] rf [NREG];
  logic [31:0] res;

  wire [7:0]      op = ir[31:24];
  wire [7:0]      cc = ir[23:16];
  wire [RIDX-1:0] ra = ir[16 +: RIDX];
  wire [RIDX-1:0] rb = ir[8 +: RIDX];
  wire [RIDX-1:0] rd = ir[0 +: RIDX];
  wire [31:0]     va = rf[ra];
  wire [31:0]     vb = rf[rb];

  wire is_alu = op <= 8'h04;
  wire is_reg = op <= 8'h05;
  wire is_mem = op == 8'h06 || op == 8'h07;
  wire is_br  = op == 8'h08 && cc <= 8'h02;
  wire taken  = cc == 8'h00 || (cc == 8'h01 && zf) || (cc == 8'h02 && !zf);

  always_comb begin
    case (op)
      8'h00:   res = va + vb;
      8'h01:   res = va - vb;
      8'h02:   res = ~va;
      8'h03:   res = va & vb;
      8'h04:   res = va | vb;
      default: res = va;
    endcase
  end

  assign mem_rd    = st == S_FETCH || st == S_ADDR || (st == S_MEM && op == 8'h06);
  assign mem_wr    = st == S_MEM && op == 8'h07;
  assign mem_addr  = st == S_MEM ? ar : pc;
  assign mem_wdata = va;
  assign halted    = st == S_HALT;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_FETCH;
      pc <= '0;
      ir <= '0;
      ar <= '0;
      zf <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      case (st)
        S_FETCH: begin
          ir <= mem_rdata;
          pc <= pc + 32'd4;
          st <= S_DECODE;
        end
        S_DECODE: begin
          if (is_reg)                 st <= S_EXEC;
          else if (is_mem || is_br)   st <= S_ADDR;
          else                        st <= S_HALT;
        end
        S_ADDR: begin
          ar <= mem_rdata;
          if (is_br) begin
            pc <= taken ? mem_rdata : pc + 32'd4;
            st <= S_FETCH;
          end else begin
            pc <= pc + 32'd4;
            st <= S_MEM;
          end
        end
        S_MEM: begin
          if (op == 8'h06) rf[rd] <= mem_rdata;
          st <= S_FETCH;
        end
        S_EXEC: begin
          rf[rd] <= res;
          if (is_alu) zf <= res == 32'd0;
          st <= S_FETCH;
        end
        default: st <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/tri_op_core_chk.sv
module tri_op_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] mem_addr,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        halted
);
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  a_r1_first_fetch: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mem_rd && mem_addr == 32'd0 && !halted));

  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !mem_rd && !mem_wr));

  a_r8_idle_before_halt: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> (!$past(mem_rd) && !$past(mem_wr)));

  a_r6_store_after_read: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> $past(mem_rd));
endmodule

bind tri_op_core tri_op_core_chk u_chk (.*);

// File: tb/tb_tri_op_core.sv
module tb_tri_op_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_addr, mem_rdata, mem_wdata;
  logic        mem_rd, mem_wr, halted;

  logic [31:0] mem [256];
  logic [31:0] mm  [256];
  logic [31:0] mr  [32];
  logic [31:0] m_pc;
  bit          m_zf, m_halt;
  int          n_chk = 0, n_fail = 0;

  typedef struct {
    bit          rd;
    bit          wr;
    logic [31:0] addr;
    logic [31:0] wd;
    bit          hl;
    string       tag;
  } cyc_t;
  cyc_t q[$];

  always #5 clk = ~clk;

  tri_op_core dut (.clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
                   .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .halted(halted));

  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;

  function automatic cyc_t mk(bit rd, bit wr, logic [31:0] a, logic [31:0] d, bit hl, string t);
    cyc_t c;
    c.rd = rd; c.wr = wr; c.addr = a; c.wd = d; c.hl = hl; c.tag = t;
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // instruction-level model that queues the expected bus activity per cycle
  task automatic step();
    logic [31:0] w, a, r, x, y;
    int op, cc, s1, s2, d;
    if (m_halt) begin
      q.push_back(mk(0, 0, 0, 0, 1, "R8"));
      return;
    end
    w  = mm[m_pc[9:2]];
    op = int'(w[31:24]); cc = int'(w[23:16]);
    s1 = int'(w[20:16]); s2 = int'(w[12:8]); d = int'(w[4:0]);   // R2: low 5 bits
    q.push_back(mk(1, 0, m_pc, 0, 0, "R2"));
    q.push_back(mk(0, 0, 0, 0, 0, "R3"));
    x = mr[s1]; y = mr[s2];
    if (op <= 5) begin
      case (op)
        0: r = x + y;
        1: r = x - y;
        2: r = ~x;
        3: r = x & y;
        4: r = x | y;
        default: r = x;
      endcase
      q.push_back(mk(0, 0, 0, 0, 0, op == 5 ? "R3" : "R4"));
      mr[d] = r;
      if (op != 5) m_zf = (r == 0);
      m_pc = m_pc + 4;
    end else if (op == 6) begin
      a = mm[(m_pc + 4) >> 2];
      q.push_back(mk(1, 0, m_pc + 4, 0, 0, "R5"));
      q.push_back(mk(1, 0, a, 0, 0, "R5"));
      mr[d] = mm[a[9:2]];
      m_pc = m_pc + 8;
    end else if (op == 7) begin
      a = mm[(m_pc + 4) >> 2];
      q.push_back(mk(1, 0, m_pc + 4, 0, 0, "R6"));
      q.push_back(mk(0, 1, a, x, 0, "R6"));
      mm[a[9:2]] = x;
      m_pc = m_pc + 8;
    end else if (op == 8 && cc <= 2) begin
      a = mm[(m_pc + 4) >> 2];
      q.push_back(mk(1, 0, m_pc + 4, 0, 0, "R7"));
      if (cc == 0 || (cc == 1 && m_zf) || (cc == 2 && !m_zf)) m_pc = a;
      else m_pc = m_pc + 8;
    end else begin
      m_halt = 1;
    end
  endtask

  task automatic run_prog(input string name);
    cyc_t e;
    int hc = 0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #1 chk(halted == 1'b0, "R1", {name, " halted in reset"}, 32'(halted), 0);
    m_pc = 0; m_zf = 0; m_halt = 0;
    foreach (mr[i]) mr[i] = 0;
    foreach (mm[i]) mm[i] = mem[i];
    q.delete();
    @(negedge clk);
    rst = 1'b0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      #1;
      if (q.size() == 0) step();
      e = q.pop_front();
      chk(mem_rd == e.rd, e.tag, {name, " read strobe"}, 32'(mem_rd), 32'(e.rd));
      chk(mem_wr == e.wr, e.tag, {name, " write strobe"}, 32'(mem_wr), 32'(e.wr));
      chk(halted == e.hl, e.tag, {name, " halted"}, 32'(halted), 32'(e.hl));
      if (e.rd || e.wr) chk(mem_addr == e.addr, e.tag, {name, " address"}, mem_addr, e.addr);
      if (e.wr) chk(mem_wdata == e.wd, e.tag, {name, " store data"}, mem_wdata, e.wd);
      if (e.hl) hc++;
      if (hc >= 4) break;
      @(negedge clk);
    end
    chk(hc >= 4, "R8", {name, " watchdog: never halted"}, 32'(hc), 4);
    foreach (mm[i]) chk(mem[i] === mm[i], "R6", {name, " final memory"}, mem[i], mm[i]);
  endtask

  task automatic clr();
    foreach (mem[i]) mem[i] = 0;
  endtask

  task automatic put(input int a, input logic [31:0] w);
    mem[a >> 2] = w;
  endtask

  initial begin
    // program A: counting loop, flag kept across MOV, taken/not-taken branches, cc=3 halt
    clr();
    put('h00, 32'h0600FF04); put('h04, 32'h100);
    put('h08, 32'h0600FF01); put('h0C, 32'h104);
    put('h10, 32'h0600FF23); put('h14, 32'h108);   // R2: index byte 0x23 -> register 3
    put('h18, 32'h05010002);
    put('h1C, 32'h00040104);
    put('h20, 32'h01030103);
    put('h24, 32'h0802FF00); put('h28, 32'h1C);
    put('h2C, 32'h0704FF00); put('h30, 32'h10C);
    put('h34, 32'h02030005);
    put('h38, 32'h03050006);
    put('h3C, 32'h05050007);                        // R4: MOV keeps flag = 1
    put('h40, 32'h0801FF00); put('h44, 32'h50);
    put('h48, 32'h0707FF00); put('h4C, 32'h110);
    put('h50, 32'h04040508);
    put('h54, 32'h0708FF00); put('h58, 32'h114);
    put('h5C, 32'h0801FF00); put('h60, 32'h48);     // R7: not taken
    put('h64, 32'h0800FF00); put('h68, 32'h74);
    put('h6C, 32'h09000000);
    put('h74, 32'h0727FF00); put('h78, 32'h110);
    put('h7C, 32'h0803FF00);                        // R8: unknown condition
    put('h100, 32'd5); put('h104, 32'd3); put('h108, 32'd9);
    run_prog("progA");
    chk(mem['h10C >> 2] == 32'd14, "R3", "progA loop sum", mem['h10C >> 2], 32'd14);
    chk(mem['h110 >> 2] == 32'hFFFFFFFF, "R7", "progA BZ skip target", mem['h110 >> 2], 32'hFFFFFFFF);

    // program B: LD after a zero result keeps the flag, unknown opcode halts
    clr();
    put('h00, 32'h01000001);
    put('h04, 32'h0600FF02); put('h08, 32'h40);
    put('h0C, 32'h0802FF00); put('h10, 32'h00);
    put('h14, 32'h0702FF00); put('h18, 32'h44);
    put('h1C, 32'h0A000000);
    put('h40, 32'd7);
    run_prog("progB");
    chk(mem['h44 >> 2] == 32'd7, "R5", "progB loaded word stored", mem['h44 >> 2], 32'd7);

    // program C: plain halt word
    clr();
    put('h00, 32'h00000000);
    put('h04, 32'h09000000);
    run_prog("progC");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule